// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output. Its time base is an 8-bit timer that runs from zero up to a programmable period value and then restarts. The timer's count is extended by a 2-bit low-order count, which gives the on-time 10 bits of resolution. With divide-by-1 prescaling the low-order count is a free-running 4-phase counter. With a prescaler active it is the upper two bits of the prescaler counter. The timer advances once every four enabled clocks times the prescale factor.

Software writes the period and a 10-bit on-time through a small write port, at any moment. The on-time is split into an 8-bit high part and a 2-bit low part that lives in the control byte. The written on-time is not used directly. It is copied into a shadow register only at the cycle where the period ends, so a write in the middle of a period never shortens or stretches the pulse in progress. The shadow value is visible on a read-only output port. The output goes high at each period start, unless the on-time copied at that moment is zero. It goes low when the 10-bit count reaches the shadow value. An on-time longer than the period keeps the output high throughout.

Top module: `pwm10_gen`

## Requirements
- R1: During and right after reset the output is low and the shadow on-time reads zero. The period register and both on-time parts also reset to zero.
- R2: Write map: address 0 holds the 8-bit period, address 1 holds on-time bits [9:2], and address 2 is the control byte whose bits [1:0] are on-time bits [1:0]. A write takes effect at the clock edge where wr_en is sampled high.
- R3: With prescale select 0 (divide by 1) and clk_en held high, a period lasts 4*(P+1) clocks and the output is high for exactly D clocks of it, where P is the period and D is the 10-bit on-time with D <= 4*(P+1).
- R4: Prescale select 1 divides by 4 and selects 2 or 3 divide by 16. Period and high time both scale by that factor, and the low-order count is then taken from prescaler bits [1:0] or [3:2] respectively.
- R5: The shadow on-time changes only at a period end, and it then takes the on-time held in the registers at that moment. A write in mid-period leaves the shadow unchanged until that point.
- R6: An on-time of zero keeps the output low for the whole period.
- R7: An on-time of 4*(P+1) or more keeps the output high without interruption.
- R8: Writing the value 0x00 to the control byte drives the output low at that same edge.
- R9: While pwm_en is low the output is held low and the timer, phase and prescaler are held at zero. Each enable therefore starts from a fresh period.
- R10: While clk_en is low, the output, the shadow on-time and the whole time base keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Advances the time base by one input clock when high |
| pwm_en | input | 1 | PWM mode enable |
| psel | input | 2 | Prescale select: 0 = /1, 1 = /4, 2 or 3 = /16 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 period, 1 on-time high, 2 control) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output latch |
| shadow_duty | output | 10 | Read-only shadow on-time in use |

## Verification
A vector table sweeps combinations of period, on-time and prescale, and counts the high clocks over exactly one period after the output has settled. Short and long on-times at /1 confirm 10-bit resolution. The /4 and /16 rows distinguish the choice of low-order bits. A zero on-time and on-times at or beyond the period length separate the suppressed set from the missing clear. Directed cases cover four further behaviours: a mid-period on-time write, where the shadow must hold and then update; a zero write to the control byte; the mode enable being dropped; and clk_en being held low, which must freeze everything.

// File: rtl/pwm10_pkg.sv
// Package: shared encodings for the PWM generator.
// Assumes a 2-bit prescale select and a 2-bit register address.
package pwm10_pkg;

    typedef enum logic [1:0] {
        PS_DIV1     = 2'd0,
        PS_DIV4     = 2'd1,
        PS_DIV16    = 2'd2,
        PS_DIV16_B  = 2'd3
    } psel_e;

    typedef enum logic [1:0] {
        RA_PERIOD  = 2'd0,
        RA_DUTY_HI = 2'd1,
        RA_CTRL    = 2'd2,
        RA_UNUSED  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pwm10_timebase.sv
// Time base: a 2-bit phase counter, a prescaler and the period timer.
// It produces the restart pulse at a period end and the 10-bit count
// value that takes effect at the next edge. Assumes PRE_W >= 4 so that
// the divide-by-16 range fits. All state is cleared while en_i is low.
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int PRE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en_i,
    input  logic               en_i,
    input  psel_e              psel_i,
    input  logic [TMR_W-1:0]   period_i,
    output logic               restart_o,
    output logic [TMR_W+1:0]   cnt_nxt_o
);
    localparam int LOW_W = 2;

    logic [LOW_W-1:0] phase_q, phase_n;
    logic [PRE_W-1:0] pre_q, pre_n;
    logic [TMR_W-1:0] tmr_q, tmr_n;
    logic [LOW_W-1:0] low_n;
    logic             phase_wrap, pre_tc, tmr_tick;

    // Decide when the prescaler and the timer step, and when a period ends.
    always_comb begin
        phase_wrap = clk_en_i && (phase_q == {LOW_W{1'b1}});
        unique case (psel_i)
            PS_DIV1: pre_tc = 1'b1;
            PS_DIV4: pre_tc = (pre_q[1:0] == 2'b11);
            default: pre_tc = (pre_q == {PRE_W{1'b1}});
        endcase
        tmr_tick  = phase_wrap && pre_tc;
        restart_o = en_i && tmr_tick && (tmr_q == period_i);
    end

    // Compute the next phase, prescaler and timer values.
    always_comb begin
        if (!en_i) begin
            phase_n = '0;
            pre_n   = '0;
            tmr_n   = '0;
        end else begin
            phase_n = clk_en_i ? phase_q + 1'b1 : phase_q;
            if (psel_i == PS_DIV1)
                pre_n = '0;
            else if (phase_wrap)
                pre_n = pre_tc ? '0 : pre_q + 1'b1;
            else
                pre_n = pre_q;
            if (restart_o)
                tmr_n = '0;
            else if (tmr_tick)
                tmr_n = tmr_q + 1'b1;
            else
                tmr_n = tmr_q;
        end
    end

    // Choose the low-order count that extends the timer to 10 bits.
    always_comb begin
        unique case (psel_i)
            PS_DIV1: low_n = phase_n;
            PS_DIV4: low_n = pre_n[1:0];
            default: low_n = pre_n[PRE_W-1 -: LOW_W];
        endcase
        cnt_nxt_o = {tmr_n, low_n};
    end

    // Register the time-base state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            pre_q   <= '0;
            tmr_q   <= '0;
        end else begin
            phase_q <= phase_n;
            pre_q   <= pre_n;
            tmr_q   <= tmr_n;
        end
    end

    // R9: disabled time base sits at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tmr_q == '0 && phase_q == '0 && pre_q == '0));

    // R3: a period end returns the timer to zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> (tmr_q == '0));

    // R4: the timer only moves on a completed phase cycle
    a_r4_tmr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !phase_wrap) |=> (tmr_q == $past(tmr_q)));

    // R10: no clock enable, no phase movement
    a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clk_en_i) |=> $stable(phase_q));

endmodule

// File: rtl/pwm10_regs.sv
// Register file: period, on-time high and low parts, and the shadow
// on-time copied at each period end. Assumes a single write per cycle;
// a write becomes visible at the edge where it is sampled.
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  reg_addr_e          wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic               restart_i,
    output logic [TMR_W-1:0]   period_o,
    output logic [TMR_W+1:0]   duty_o,
    output logic [TMR_W+1:0]   shadow_o,
    output logic               ctrl_zero_o
);
    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] duty_hi_q;
    logic [1:0]       duty_lo_q;
    logic [TMR_W+1:0] shadow_q;

    // Detect a write of zero to the control byte.
    always_comb begin
        ctrl_zero_o = wr_en_i && (wr_addr_i == RA_CTRL) && (wr_data_i == 8'h00);
    end

    // Capture software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q  <= '0;
            duty_hi_q <= '0;
            duty_lo_q <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                RA_PERIOD:  period_q  <= wr_data_i[TMR_W-1:0];
                RA_DUTY_HI: duty_hi_q <= wr_data_i[TMR_W-1:0];
                RA_CTRL:    duty_lo_q <= wr_data_i[1:0];
                default:    ;
            endcase
        end
    end

    // Copy the on-time into the shadow register at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (restart_i)
            shadow_q <= {duty_hi_q, duty_lo_q};
    end

    assign period_o = period_q;
    assign duty_o   = {duty_hi_q, duty_lo_q};
    assign shadow_o = shadow_q;

    // R5: the shadow moves only at a period end
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> (shadow_q == $past(shadow_q)));

    // R5: at a period end the shadow takes the programmed on-time
    a_r5_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !wr_en_i) |=> (shadow_q == duty_o));

endmodule

// File: rtl/pwm10_out.sv
// Output latch: set at a period start when the new on-time is nonzero,
// cleared when the next 10-bit count equals the shadow on-time, and
// forced low by a zero control write or by the mode being disabled.
module pwm10_out #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_i,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic             ctrl_zero_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [CNT_W-1:0] shadow_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             pwm_o
);
    logic out_q;

    // Update the output latch; forced clears take priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else if (!en_i || ctrl_zero_i)
            out_q <= 1'b0;
        else if (restart_i)
            out_q <= (duty_i != '0);
        else if (clk_en_i && (cnt_nxt_i == shadow_i))
            out_q <= 1'b0;
    end

    assign pwm_o = out_q;

    // R6: a zero on-time never raises the output
    a_r6_zero_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && duty_i == '0) |=> !pwm_o);

    // R8: zero control write clears the output
    a_r8_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero_i |=> !pwm_o);

    // R9: disabled mode holds the output low
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);

    // R10: no clock enable, output unchanged
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clk_en_i && !ctrl_zero_i) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm10_gen.sv
// Top: double-buffered PWM generator. It ties the time base, the
// register file and the output latch together. Assumes an 8-bit write
// bus and a timer no wider than that bus.
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int PRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              pwm_en,
    input  logic [1:0]        psel,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              pwm_out,
    output logic [TMR_W+1:0]  shadow_duty
);
    localparam int CNT_W = TMR_W + 2;

    logic             restart;
    logic [CNT_W-1:0] cnt_nxt;
    logic [TMR_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] shadow;
    logic             ctrl_zero;

    pwm10_timebase #(.TMR_W(TMR_W), .PRE_W(PRE_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_i  (clk_en),
        .en_i      (pwm_en),
        .psel_i    (psel_e'(psel)),
        .period_i  (period),
        .restart_o (restart),
        .cnt_nxt_o (cnt_nxt)
    );

    pwm10_regs #(.TMR_W(TMR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (reg_addr_e'(wr_addr)),
        .wr_data_i   (wr_data),
        .restart_i   (restart),
        .period_o    (period),
        .duty_o      (duty),
        .shadow_o    (shadow),
        .ctrl_zero_o (ctrl_zero)
    );

    pwm10_out #(.CNT_W(CNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en_i    (clk_en),
        .en_i        (pwm_en),
        .restart_i   (restart),
        .ctrl_zero_i (ctrl_zero),
        .duty_i      (duty),
        .shadow_i    (shadow),
        .cnt_nxt_i   (cnt_nxt),
        .pwm_o       (pwm_out)
    );

    assign shadow_duty = shadow;

endmodule

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n, clk_en, pwm_en, wr_en;
    logic [1:0] psel, wr_addr;
    logic [7:0] wr_data;
    logic       pwm_out;
    logic [9:0] shadow_duty;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm10_gen u_pwm10_gen (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwm_en(pwm_en),
        .psel(psel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .shadow_duty(shadow_duty)
    );

    localparam int NV = 9;
    localparam int VP [NV] = '{3, 3, 3, 7, 2, 1, 1, 0, 9};
    localparam int VD [NV] = '{5, 16, 0, 13, 7, 3, 100, 2, 39};
    localparam int VS [NV] = '{0, 0, 0, 0, 1, 2, 3, 0, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int p, input int d, input int s);
        @(negedge clk);
        pwm_en = 1'b0;
        wr(0, p);
        wr(1, d >> 2);
        wr(2, d & 3);
        psel = s[1:0];
        @(negedge clk);
        pwm_en = 1'b1;
    endtask

    function automatic int pres(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : 16;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en = 1'b1; pwm_en = 1'b0; wr_en = 1'b0;
        psel = 2'd0; wr_addr = 2'd0; wr_data = 8'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pwm_out == 1'b0, "R1 out in reset", pwm_out, 0);
        check(shadow_duty == 10'd0, "R1 shadow in reset", shadow_duty, 0);
        rst_n = 1'b1;
        pwm_en = 1'b1;
        repeat (12) @(negedge clk);
        check(pwm_out == 1'b0, "R1 out after reset", pwm_out, 0);

        // Vector table: high clocks over one period (R2 R3 R4 R6 R7)
        for (int i = 0; i < NV; i++) begin
            int n, e, hi;
            n = 4 * (VP[i] + 1) * pres(VS[i]);
            e = ((VD[i] < 4 * (VP[i] + 1)) ? VD[i] : 4 * (VP[i] + 1)) * pres(VS[i]);
            cfg(VP[i], VD[i], VS[i]);
            repeat (2 * n + 8) @(negedge clk);
            hi = 0;
            for (int k = 0; k < n; k++) begin
                @(negedge clk);
                if (pwm_out) hi++;
            end
            if (VD[i] == 0)
                check(hi == 0, "R6 zero on-time", hi, 0);
            else if (VD[i] >= 4 * (VP[i] + 1))
                check(hi == n, "R7 full on-time", hi, n);
            else if (VS[i] == 0)
                check(hi == e, "R3 high clocks", hi, e);
            else
                check(hi == e, "R4 prescaled high clocks", hi, e);
            check(shadow_duty == VD[i][9:0], "R2 shadow from write map", shadow_duty, VD[i]);
        end

        // R5: double buffering of a mid-period write
        cfg(15, 20, 0);
        repeat (136) @(negedge clk);
        wr(1, 10);
        check(shadow_duty == 10'd20, "R5 shadow held", shadow_duty, 20);
        repeat (70) @(negedge clk);
        check(shadow_duty == 10'd40, "R5 shadow updated", shadow_duty, 40);

        // R8: zero control write forces the output low
        cfg(3, 32, 0);
        repeat (40) @(negedge clk);
        check(pwm_out == 1'b1, "R7 steady high", pwm_out, 1);
        wr(2, 0);
        check(pwm_out == 1'b0, "R8 control clear", pwm_out, 0);

        // R10: clock enable low freezes output and shadow
        begin
            logic o0;
            logic [9:0] s0;
            int bad;
            cfg(7, 13, 0);
            repeat (72) @(negedge clk);
            clk_en = 1'b0;
            o0 = pwm_out; s0 = shadow_duty; bad = 0;
            repeat (30) begin
                @(negedge clk);
                if (pwm_out != o0 || shadow_duty != s0) bad++;
            end
            check(bad == 0, "R10 frozen", bad, 0);
            clk_en = 1'b1;
        end

        // R9: mode disable holds output low
        begin
            int hi;
            cfg(3, 32, 0);
            repeat (40) @(negedge clk);
            pwm_en = 1'b0;
            hi = 0;
            repeat (12) begin
                @(negedge clk);
                if (pwm_out) hi++;
            end
            check(hi == 0, "R9 disabled low", hi, 0);
            pwm_en = 1'b1;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule